// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides when the CPU of a small microcontroller core is halted, and when the oscillator and peripheral clocks are gated. Software puts the core into one of two low-power modes by writing a key value into a write-only control register on the peripheral bus. In the light mode (idle), only the CPU is frozen and every clock keeps running. In the deep mode (halt-all), the oscillator and the peripheral clocks are switched off as well. The deep mode needs two steps: software arms the register, then executes the power-down instruction, which arrives at this block as a strobe.

An enabled interrupt releases either mode, and so does reset. When the deep mode is left, the clocks restart at once, but the CPU stays frozen until an 8-bit settling counter has run from 00h through FFh and overflowed. The counter is driven by a prescaler whose ratio is chosen before entry. On every interrupt release, the block gives a one-cycle strobe. With it comes a flag that tells the CPU either to take the interrupt vector or to carry on with the next instruction.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset, cpu_halt is 0, osc_en and pclk_en are 1, wake_stb is 0, and the control register holds 00h, so a power-down strobe has no effect.
- R2: A bus write of 0Fh to address F5h while running sets cpu_halt from the next cycle on (idle mode), with osc_en and pclk_en kept at 1.
- R3: A power-down strobe while the register holds 5Ah enters halt-all mode from the next cycle on: cpu_halt is 1, and osc_en and pclk_en are 0.
- R4: A power-down strobe while the register holds any value other than 5Ah leaves the block running. A write of 00h disarms a previous 5Ah. Writes of other values, and writes to any address other than F5h, never halt the CPU.
- R5: A mode is left only by a request line that is pending in irq_pend and was set in irq_en at the cycle of entry. Pending lines that were not enabled, and enables set during the mode, do not wake the block.
- R6: In idle mode, cpu_halt falls in the cycle after the clock edge that samples the wake request.
- R7: In halt-all mode, osc_en and pclk_en return to 1 in the cycle after the wake edge. cpu_halt falls exactly 256 × 2^(sel+1) cycles after the wake edge, where sel is the value of presc_sel at the cycle of entry.
- R8: On each interrupt release, wake_stb is 1 for exactly the first running cycle. wake_vector then equals gie as sampled at the release edge: 1 means take the vector, 0 means resume.
- R9: Leaving halt-all mode clears the control register, so a later power-down strobe without a fresh 5Ah write does not halt.
- R10: Reset leaves either mode in the next cycle without a wake strobe and clears the register. Reset wins over a wake request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Peripheral bus write enable |
| bus_addr | input | ADDR_W | Peripheral bus address |
| bus_wdata | input | 8 | Peripheral bus write data |
| stop_exec | input | 1 | Pulse marking execution of the power-down instruction |
| irq_pend | input | N_IRQ | Pending interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt flag |
| presc_sel | input | PSEL_W | Settling prescaler select, divide by 2^(sel+1) |
| cpu_halt | output | 1 | CPU freeze request |
| osc_en | output | 1 | Oscillator enable |
| pclk_en | output | 1 | Peripheral clock enable |
| wake_stb | output | 1 | One-cycle interrupt release strobe |
| wake_vector | output | 1 | 1 = take the interrupt vector, 0 = resume with the next instruction |

## Verification
Two functions can fall in the same clock edge: reset, and an enabled interrupt that would release halt-all mode. The bench raises an enabled pending line in the same cycle that it asserts reset while the block is in halt-all mode. It then requires that the CPU runs again at once, that osc_en comes back, and that wake_stb stays low both in the first running cycle and in the cycle after. It also requires that the register has been cleared, so that the next power-down strobe does nothing. The settling delay is swept over seven prescaler settings, with the release edge computed as 256 × 2^(sel+1).

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_HALT  = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_e;

    localparam logic [7:0] KEY_IDLE     = 8'h0F;
    localparam logic [7:0] KEY_HALT_ARM = 8'h5A;

    typedef struct packed {
        logic idle_req;
        logic halt_armed;
    } ctl_cmd_t;

    // Terminal value of the prescaler count for divide-by 2^(sel+1)
    function automatic int unsigned prescale_last(input int unsigned sel);
        return (32'd1 << (sel + 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/pdc_ctl_reg.sv
module pdc_ctl_reg #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 'hF5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    input  logic                  clr,
    output pdc_pkg::ctl_cmd_t     cmd
);
    import pdc_pkg::*;

    logic [7:0] key_q;
    logic       wr_hit;

    assign wr_hit = wr_en && (addr == CTL_ADDR);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            key_q <= 8'h00;
        end else if (wr_hit) begin
            key_q <= wdata;
        end
    end

    always_comb begin
        cmd.idle_req   = wr_hit && (wdata == KEY_IDLE);
        cmd.halt_armed = (key_q == KEY_HALT_ARM);
    end

    // R9: automatic clear on leaving halt-all mode disarms the register
    p_clear_disarms_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !cmd.halt_armed);

endmodule

// File: rtl/pdc_wake_gate.sv
module pdc_wake_gate #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_pend,
    output logic             wake
);
    logic [N_IRQ-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (capture) begin
            mask_q <= irq_en;
        end
    end

    assign wake = |(irq_pend & mask_q);

endmodule

// File: rtl/pdc_settle_timer.sv
module pdc_settle_timer #(
    parameter int PSEL_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [PSEL_W-1:0] sel,
    output logic              done
);
    import pdc_pkg::*;

    localparam int PRE_W = 1 << PSEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_last;
    logic             tick;

    assign pre_last = (pre_q == PRE_W'(prescale_last(int'(sel))));
    assign tick     = run && pre_last;
    assign done     = tick && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_last) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R7: settling count only ever holds or steps by one while running
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(done)) |->
            (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm #(
    parameter int PSEL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pdc_pkg::ctl_cmd_t      cmd,
    input  logic                   stop_exec,
    input  logic                   wake,
    input  logic                   settle_done,
    input  logic                   gie,
    input  logic [PSEL_W-1:0]      presc_sel,
    output logic                   capture,
    output logic                   key_clr,
    output logic                   settling,
    output logic [PSEL_W-1:0]      sel_q,
    output logic                   cpu_halt,
    output logic                   osc_en,
    output logic                   pclk_en,
    output logic                   wake_stb,
    output logic                   wake_vector
);
    import pdc_pkg::*;

    pm_state_e state_q, state_d;
    logic      release_d;

    always_comb begin
        state_d   = state_q;
        release_d = 1'b0;
        capture   = 1'b0;
        key_clr   = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                if (cmd.idle_req) begin
                    state_d = PM_IDLE;
                    capture = 1'b1;
                end else if (stop_exec && cmd.halt_armed) begin
                    state_d = PM_HALT;
                    capture = 1'b1;
                end
            end
            PM_IDLE: begin
                if (wake) begin
                    state_d   = PM_RUN;
                    release_d = 1'b1;
                end
            end
            PM_HALT: begin
                if (wake) begin
                    state_d = PM_SETTLE;
                    key_clr = 1'b1;
                end
            end
            PM_SETTLE: begin
                if (settle_done) begin
                    state_d   = PM_RUN;
                    release_d = 1'b1;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PM_RUN;
            sel_q       <= '0;
            wake_stb    <= 1'b0;
            wake_vector <= 1'b0;
        end else begin
            state_q  <= state_d;
            wake_stb <= release_d;
            if (release_d) begin
                wake_vector <= gie;
            end
            if (state_q == PM_RUN && state_d == PM_HALT) begin
                sel_q <= presc_sel;
            end
        end
    end

    assign settling = (state_q == PM_SETTLE);
    assign cpu_halt = (state_q != PM_RUN);
    assign osc_en   = (state_q != PM_HALT);
    assign pclk_en  = (state_q != PM_HALT);

    // R3: an armed strobe in run mode enters halt-all
    p_halt_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && stop_exec && cmd.halt_armed && !cmd.idle_req)
            |=> (state_q == PM_HALT));

    // R4: without a key, run mode persists
    p_unarmed_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && !cmd.halt_armed && !cmd.idle_req)
            |=> (state_q == PM_RUN));

    // R5: idle mode holds until a masked-in request appears
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_IDLE && !wake) |=> (state_q == PM_IDLE));

    // R7: settling holds until the counter overflows
    p_settle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_SETTLE && !settle_done) |=> (state_q == PM_SETTLE));

    // R8: release strobe lasts one cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        wake_stb |=> !wake_stb);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int N_IRQ  = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 'hF5,
    parameter int PSEL_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              stop_exec,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              gie,
    input  logic [PSEL_W-1:0] presc_sel,
    output logic              cpu_halt,
    output logic              osc_en,
    output logic              pclk_en,
    output logic              wake_stb,
    output logic              wake_vector
);
    import pdc_pkg::*;

    ctl_cmd_t          cmd;
    logic              capture;
    logic              key_clr;
    logic              wake;
    logic              settling;
    logic              settle_done;
    logic [PSEL_W-1:0] sel_q;

    pdc_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .clr   (key_clr),
        .cmd   (cmd)
    );

    pdc_wake_gate #(.N_IRQ(N_IRQ)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .irq_en   (irq_en),
        .irq_pend (irq_pend),
        .wake     (wake)
    );

    pdc_settle_timer #(.PSEL_W(PSEL_W), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (settling),
        .sel  (sel_q),
        .done (settle_done)
    );

    pdc_mode_fsm #(.PSEL_W(PSEL_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .stop_exec   (stop_exec),
        .wake        (wake),
        .settle_done (settle_done),
        .gie         (gie),
        .presc_sel   (presc_sel),
        .capture     (capture),
        .key_clr     (key_clr),
        .settling    (settling),
        .sel_q       (sel_q),
        .cpu_halt    (cpu_halt),
        .osc_en      (osc_en),
        .pclk_en     (pclk_en),
        .wake_stb    (wake_stb),
        .wake_vector (wake_vector)
    );

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       stop_exec = 1'b0;
    logic [7:0] irq_pend = 8'h00;
    logic [7:0] irq_en = 8'h00;
    logic       gie = 1'b0;
    logic [2:0] presc_sel = 3'd0;
    logic       cpu_halt, osc_en, pclk_en, wake_stb, wake_vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stop_exec(stop_exec), .irq_pend(irq_pend),
        .irq_en(irq_en), .gie(gie), .presc_sel(presc_sel),
        .cpu_halt(cpu_halt), .osc_en(osc_en), .pclk_en(pclk_en),
        .wake_stb(wake_stb), .wake_vector(wake_vector)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_exec = 1'b1;
        tick();
        stop_exec = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        check("R1 halt", cpu_halt, 0);
        check("R1 osc", osc_en, 1);
        check("R1 pclk", pclk_en, 1);
        check("R1 stb", wake_stb, 0);
        pulse_stop();
        check("R1 strobe with cleared register", cpu_halt, 0);

        // R4: wrong address, wrong key, disarm
        bus_write(8'hF4, 8'h0F);
        check("R4 other address", cpu_halt, 0);
        bus_write(8'hF5, 8'h33);
        check("R4 other key", cpu_halt, 0);
        pulse_stop();
        check("R4 strobe with 33h", cpu_halt, 0);
        bus_write(8'hF5, 8'h5A);
        bus_write(8'hF5, 8'h00);
        pulse_stop();
        check("R4 disarmed by 00h", cpu_halt, 0);
        bus_write(8'hF5, 8'h0F);
        // idle mode entered here; strobe with 0Fh is checked below after wake

        // R2: idle mode entry (mask captured with irq_en = 00h here)
        check("R2 halt", cpu_halt, 1);
        check("R2 osc", osc_en, 1);
        check("R2 pclk", pclk_en, 1);
        // R10: reset releases idle mode
        rst = 1'b1; tick(); rst = 1'b0;
        check("R10 idle reset halt", cpu_halt, 0);
        check("R10 idle reset stb", wake_stb, 0);

        // R5: masking of wake requests
        irq_en = 8'h04;
        bus_write(8'hF5, 8'h0F);
        check("R2 idle again", cpu_halt, 1);
        irq_pend = 8'h01;
        repeat (3) tick();
        check("R5 unenabled pending", cpu_halt, 1);
        irq_en = 8'h01;
        repeat (3) tick();
        check("R5 late enable", cpu_halt, 1);
        irq_en = 8'h04;
        irq_pend = 8'h04;
        gie = 1'b0;
        tick();
        irq_pend = 8'h00;
        // R6 and R8: idle release, resume
        check("R6 idle wake halt", cpu_halt, 0);
        check("R8 idle stb", wake_stb, 1);
        check("R8 idle resume", wake_vector, 0);
        tick();
        check("R8 stb single", wake_stb, 0);
        pulse_stop();
        check("R4 strobe with 0Fh", cpu_halt, 0);

        // R3, R7, R8, R9: halt-all sweep over prescaler settings
        for (int n = 0; n < 7; n++) begin
            int div;
            div = 1 << (n + 1);
            gie = n[0];
            presc_sel = 3'(n);
            irq_en = 8'h80;
            bus_write(8'hF5, 8'h5A);
            pulse_stop();
            check("R3 halt", cpu_halt, 1);
            check("R3 osc off", osc_en, 0);
            check("R3 pclk off", pclk_en, 0);
            presc_sel = 3'(6 - n);
            irq_pend = 8'h40;
            repeat (2) tick();
            check("R5 halt unenabled", osc_en, 0);
            irq_pend = 8'h80;
            tick();
            irq_pend = 8'h00;
            check("R7 osc back", osc_en, 1);
            check("R7 pclk back", pclk_en, 1);
            check("R7 still halted", cpu_halt, 1);
            repeat (256 * div - 1) tick();
            check("R7 halted before release", cpu_halt, 1);
            tick();
            check("R7 released", cpu_halt, 0);
            check("R8 stb", wake_stb, 1);
            check("R8 vector", wake_vector, 32'(n[0]));
            tick();
            check("R8 stb single", wake_stb, 0);
            pulse_stop();
            check("R9 register cleared", cpu_halt, 0);
        end

        // R10: reset collides with wake in halt-all mode
        irq_en = 8'h02;
        bus_write(8'hF5, 8'h5A);
        pulse_stop();
        check("R10 halt entered", osc_en, 0);
        rst = 1'b1;
        irq_pend = 8'h02;
        tick();
        rst = 1'b0;
        irq_pend = 8'h00;
        check("R10 halt cleared", cpu_halt, 0);
        check("R10 osc", osc_en, 1);
        check("R10 no stb", wake_stb, 0);
        tick();
        check("R10 no stb later", wake_stb, 0);
        pulse_stop();
        check("R10 register cleared", cpu_halt, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule